// File: doc/BRIEF.md
# Transmit Frame FIFO with Length and Status Queues

This block is the transmit half of a frame interface driven by software through a small register file. Software first writes 32-bit data words into a packet FIFO. It then starts each frame by writing a byte count into a length queue. A transmit engine takes lengths from that queue one at a time and sends the matching number of bytes over a byte-serial valid/ready output, least-significant byte of each word first, with `tx_last` on the final byte. Every frame starts on a fresh data word. The unused tail bytes of a frame's last word are dropped and are not counted in the frame length.

When a frame ends, the engine pushes a status word into a status queue. Software pops the status queue by reading the status register. A write-1-to-clear done bit stays set for as long as status words remain queued, so software can loop (pop, clear, re-read) until done stays low. If a frame's length is larger than the data held in the packet FIFO, the frame ends early and its status carries an underrun flag. This is not fatal.

Queue misuse sets sticky fatal bits that writes to the interrupt status register cannot clear. A packet FIFO overflow sets a sticky device error. Only reset or the soft-reset control bit clears these. The interrupt output is the OR of the interrupt status bits masked by an enable register.

Engine states: IDLE (wait for a length, pop it: IDLE→FETCH), FETCH (pop a data word: FETCH→SEND, or, with the packet FIFO empty, underrun: FETCH→REPORT), SEND (present one byte per handshake; word used up: SEND→FETCH; last byte taken: SEND→REPORT), REPORT (push status: REPORT→IDLE). A soft reset forces any state back to IDLE.

Top module: `tfq_tx_frame_fifo`

## Requirements
- R1: Register map by `bus_addr`: 0 control (write bit0=1 is soft reset), 1 data push, 2 length push (bits 15:0), 3 status pop, 4 interrupt status, 5 interrupt enable (bits 4:0), 6 device status. No byte leaves until a nonzero length is written. A length of zero is ignored and queues nothing.
- R2: Bytes leave least-significant byte first (bits 7:0 first). `tx_last` is high only on the final byte of a complete frame. `tx_valid`, `tx_data` and `tx_last` hold steady while `tx_ready` is low.
- R3: Each frame starts at byte 0 of a new word. The unsent bytes of a frame's final word are discarded.
- R4: If a frame needs a word while the packet FIFO is empty, the frame stops with no `tx_last`. Its status has bit31 (error) and bit30 (underrun) set and the bytes sent in bits 15:0. Later frames run normally with no reset.
- R5: A status word is {bit31 error, bit30 underrun, bits15:0 byte count}, and a clean frame returns its length. Reading register 3 pops the oldest status. Reading it while the queue is empty returns 0 and sets interrupt status bit4.
- R6: Interrupt status bit0 (done) sets when a frame reports. Writing 1 to it clears it only if no status word is left queued after that cycle; otherwise it stays set.
- R7: Interrupt status bit1 shows the length queue (16 entries) is full. A length written while it is full is dropped and sets bit2.
- R8: A data write while the packet FIFO (512 words) is full is dropped and sets device status bit0, which stays set until reset or soft reset.
- R9: A frame that reports while the status queue (16 entries) is full loses its status and sets interrupt status bit3. Bits 4:2 ignore write-1-to-clear.
- R10: `irq` and device status bit1 equal the OR of (interrupt status AND interrupt enable).
- R11: Soft reset empties all three queues, clears done and every sticky error bit, and returns the engine to IDLE.
- R12: After reset, `tx_valid` and `irq` are low and the interrupt status and device status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the status queue at address 3) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets frames whose lengths end mid-word. A design that kept the leftover bytes would shift every later frame. It also checks lengths larger than the buffered data: a wrong design would hang, emit `tx_last` or need a reset. The done bit is cleared with statuses still queued, where a plain sticky flag would go low too early. Full length and status queues and a full packet FIFO are driven to confirm writes are dropped and the fatal bits survive write-1-to-clear. Random lengths and random `tx_ready` back-pressure are compared byte by byte against a word-stream model.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_ISR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IER  = 3'd5;
    localparam logic [ADDR_W-1:0] A_DEV  = 3'd6;

    localparam int ISR_W  = 5;
    localparam int I_DONE = 0;
    localparam int I_LFUL = 1;
    localparam int I_LOVF = 2;
    localparam int I_SOVF = 3;
    localparam int I_SUNF = 4;

    localparam int S_ERR  = 31;
    localparam int S_URUN = 30;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_REPORT
    } tx_state_t;
endpackage

// File: rtl/tfq_sync_fifo.sv
module tfq_sync_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(count));
endmodule

// File: rtl/tfq_tx_engine.sv
module tfq_tx_engine
    import tfq_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              len_empty,
    input  logic [LEN_W-1:0]  len_data,
    output logic              len_pop,
    input  logic              pk_empty,
    input  logic [WORD_W-1:0] pk_data,
    output logic              pk_pop,
    output logic              st_push,
    output logic [31:0]       st_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    tx_state_t         state, nxt;
    logic [LEN_W-1:0]  remain, sent;
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic              urun;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_IDLE;
        else if (flush) state <= ST_IDLE;
        else            state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        len_pop  = 1'b0;
        pk_pop   = 1'b0;
        st_push  = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!len_empty) begin
                    len_pop = 1'b1;
                    nxt     = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (pk_empty) begin
                    nxt = ST_REPORT;
                end else begin
                    pk_pop = 1'b1;
                    nxt    = ST_SEND;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = (remain == LEN_W'(1));
                if (tx_ready) begin
                    if (remain == LEN_W'(1))         nxt = ST_REPORT;
                    else if (idx == IDX_W'(BYTES-1)) nxt = ST_FETCH;
                end
            end
            ST_REPORT: begin
                st_push = 1'b1;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign tx_data = word[idx*8 +: 8];

    always_comb begin
        st_data                = '0;
        st_data[S_ERR]         = urun;
        st_data[S_URUN]        = urun;
        st_data[LEN_W-1:0]     = sent;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            sent   <= '0;
            word   <= '0;
            idx    <= '0;
            urun   <= 1'b0;
        end else if (!flush) begin
            if (state == ST_IDLE && !len_empty) begin
                remain <= len_data;
                sent   <= '0;
                urun   <= 1'b0;
            end
            if (state == ST_FETCH) begin
                if (pk_empty) begin
                    urun <= 1'b1;
                end else begin
                    word <= pk_data;
                    idx  <= '0;
                end
            end
            if (state == ST_SEND && tx_ready) begin
                remain <= remain - LEN_W'(1);
                sent   <= sent + LEN_W'(1);
                idx    <= idx + IDX_W'(1);
            end
        end
    end

    a_r2_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush) |=>
            (tx_valid && $stable(tx_data) && $stable(tx_last)));

    a_r1_send_has_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (remain != '0));

    a_r3_send_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> ($past(state) == ST_FETCH));
endmodule

// File: rtl/tfq_tx_frame_fifo.sv
module tfq_tx_frame_fifo
    import tfq_pkg::*;
#(
    parameter int PKT_DEPTH  = 512,
    parameter int LEN_DEPTH  = 16,
    parameter int STAT_DEPTH = 16,
    parameter int LEN_W      = 16,
    localparam int PCW       = $clog2(PKT_DEPTH + 1),
    localparam int LCW       = $clog2(LEN_DEPTH + 1),
    localparam int SCW       = $clog2(STAT_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);
    logic              flush;
    logic              wr_data, wr_len, rd_stat, clr_done;
    logic [LEN_W-1:0]  len_field;

    logic              pk_full, pk_empty, pk_pop;
    logic [31:0]       pk_dout;
    logic [PCW-1:0]    pk_count;
    logic              lq_full, lq_empty, lq_pop;
    logic [LEN_W-1:0]  lq_dout;
    logic [LCW-1:0]    lq_count;
    logic              sq_full, sq_empty, sq_push;
    logic [31:0]       sq_dout, st_data;
    logic [SCW-1:0]    sq_count;
    logic              sq_left;

    logic              done_q, lovf_q, sovf_q, sunf_q, perr_q;
    logic [ISR_W-1:0]  ier_q, isr;

    assign flush     = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
    assign wr_data   = bus_wr && (bus_addr == A_DATA);
    assign len_field = bus_wdata[LEN_W-1:0];
    assign wr_len    = bus_wr && (bus_addr == A_LEN) && (len_field != '0);
    assign rd_stat   = bus_rd && (bus_addr == A_STAT);
    assign clr_done  = bus_wr && (bus_addr == A_ISR) && bus_wdata[I_DONE];
    assign sq_left   = sq_count > SCW'(rd_stat && !sq_empty);

    tfq_sync_fifo #(.W(32), .DEPTH(PKT_DEPTH)) u_pkt (
        .clk, .rst_n, .clr(flush),
        .push(wr_data), .din(bus_wdata), .pop(pk_pop), .dout(pk_dout),
        .full(pk_full), .empty(pk_empty), .count(pk_count));

    tfq_sync_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_lenq (
        .clk, .rst_n, .clr(flush),
        .push(wr_len), .din(len_field), .pop(lq_pop), .dout(lq_dout),
        .full(lq_full), .empty(lq_empty), .count(lq_count));

    tfq_sync_fifo #(.W(32), .DEPTH(STAT_DEPTH)) u_statq (
        .clk, .rst_n, .clr(flush),
        .push(sq_push), .din(st_data), .pop(rd_stat), .dout(sq_dout),
        .full(sq_full), .empty(sq_empty), .count(sq_count));

    tfq_tx_engine #(.LEN_W(LEN_W), .WORD_W(32)) u_eng (
        .clk, .rst_n, .flush,
        .len_empty(lq_empty), .len_data(lq_dout), .len_pop(lq_pop),
        .pk_empty(pk_empty), .pk_data(pk_dout), .pk_pop(pk_pop),
        .st_push(sq_push), .st_data(st_data),
        .tx_valid, .tx_data, .tx_last, .tx_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            lovf_q <= 1'b0;
            sovf_q <= 1'b0;
            sunf_q <= 1'b0;
            perr_q <= 1'b0;
            ier_q  <= '0;
        end else if (flush) begin
            done_q <= 1'b0;
            lovf_q <= 1'b0;
            sovf_q <= 1'b0;
            sunf_q <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (sq_push)        done_q <= 1'b1;
            else if (clr_done)  done_q <= sq_left;
            if (bus_wr && bus_addr == A_LEN && len_field != '0 && lq_full) lovf_q <= 1'b1;
            if (sq_push && sq_full)  sovf_q <= 1'b1;
            if (rd_stat && sq_empty) sunf_q <= 1'b1;
            if (wr_data && pk_full)  perr_q <= 1'b1;
            if (bus_wr && bus_addr == A_IER) ier_q <= bus_wdata[ISR_W-1:0];
        end
    end

    always_comb begin
        isr         = '0;
        isr[I_DONE] = done_q;
        isr[I_LFUL] = lq_full;
        isr[I_LOVF] = lovf_q;
        isr[I_SOVF] = sovf_q;
        isr[I_SUNF] = sunf_q;
    end

    assign irq = |(isr & ier_q);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT:  bus_rdata = sq_empty ? 32'd0 : sq_dout;
            A_ISR:   bus_rdata[ISR_W-1:0] = isr;
            A_IER:   bus_rdata[ISR_W-1:0] = ier_q;
            A_DEV:   bus_rdata[1:0] = {irq, perr_q};
            default: bus_rdata = '0;
        endcase
    end

    a_r1_zero_length_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LEN && len_field == '0 && !lq_pop) |=> $stable(lq_count));

    a_r9_fatal_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((lovf_q || sovf_q || sunf_q) && !flush) |=> (lovf_q || sovf_q || sunf_q));

    a_r6_done_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !flush && sq_count > SCW'(1)) |=> done_q);

    a_r8_pkt_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_q && !flush) |=> perr_q);

    a_r8_pkt_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pk_count <= PCW'(PKT_DEPTH));
endmodule

// File: tb/tfq_tx_frame_fifo_bench.sv
module tfq_tx_frame_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 2; // 0 low, 1 random, 2 high

    int unsigned words_q[$];
    logic [8:0]  exp_q[$];
    logic [8:0]  cap_q[$];
    logic [31:0] stat_q[$];

    always #5 clk = ~clk;

    tfq_tx_frame_fifo u_tfq_tx_frame_fifo (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .tx_valid, .tx_data, .tx_last, .tx_ready, .irq);

    always @(negedge clk) begin
        case (rdy_mode)
            0:       tx_ready = 1'b0;
            1:       tx_ready = 1'($urandom_range(0, 1));
            default: tx_ready = 1'b1;
        endcase
        if (tx_valid && tx_ready) cap_q.push_back({tx_last, tx_data});
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_word(input int unsigned w);
        bus_write(3'd1, w);
        words_q.push_back(w);
    endtask

    // expected bytes and status for one frame of len bytes
    function automatic void model_frame(input int len, input bit keep_stat);
        int need = (len + 3) / 4;
        int avail = words_q.size();
        int n;
        logic [31:0] st;
        if (need <= avail) begin
            for (int i = 0; i < len; i++)
                exp_q.push_back({(i == len - 1), 8'(words_q[i/4] >> (8 * (i % 4)))});
            for (int i = 0; i < need; i++) void'(words_q.pop_front());
            st = 32'(len);
        end else begin
            n = 4 * avail;
            for (int i = 0; i < n; i++)
                exp_q.push_back({1'b0, 8'(words_q[i/4] >> (8 * (i % 4)))});
            words_q.delete();
            st = 32'hC000_0000 | 32'(n);
        end
        if (keep_stat) stat_q.push_back(st);
    endfunction

    task automatic send_frame(input int len);
        bus_write(3'd2, 32'(len));
        model_frame(len, 1'b1);
    endtask

    task automatic compare_stream(input string req);
        int bad = 0;
        repeat (400) @(negedge clk);
        check(cap_q.size() == exp_q.size(), req, "byte count",
              32'(cap_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < cap_q.size() && i < exp_q.size(); i++)
            if (cap_q[i] !== exp_q[i]) begin
                if (bad == 0)
                    check(1'b0, req, $sformatf("byte %0d {last,data}", i),
                          32'(cap_q[i]), 32'(exp_q[i]));
                bad++;
            end
        if (bad == 0) check(1'b1, req, "stream content", 0, 0);
        cap_q.delete();
        exp_q.delete();
    endtask

    task automatic drain_status(input string req);
        logic [31:0] d;
        while (stat_q.size() > 0) begin
            bus_read(3'd3, d);
            check(d === stat_q[0], req, "status word", d, stat_q[0]);
            void'(stat_q.pop_front());
        end
    endtask

    task automatic soft_reset();
        bus_write(3'd0, 32'd1);
        words_q.delete(); exp_q.delete(); stat_q.delete(); cap_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual 0x%08h expected 0x%08h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        check(tx_valid === 1'b0, "R12", "tx_valid after reset", 32'(tx_valid), 0);
        check(irq === 1'b0, "R12", "irq after reset", 32'(irq), 0);
        bus_read(3'd4, d); check(d === 0, "R12", "ISR after reset", d, 0);
        bus_read(3'd6, d); check(d === 0, "R12", "DEV after reset", d, 0);

        // R1 no send before length, zero length ignored
        push_word(32'h4433_2211);
        push_word(32'h8877_6655);
        push_word(32'hCCBB_AA99);
        bus_write(3'd2, 32'd0);
        repeat (20) @(negedge clk);
        check(cap_q.size() == 0, "R1", "bytes before nonzero length", 32'(cap_q.size()), 0);
        bus_read(3'd4, d); check(d[0] === 1'b0, "R1", "done after zero length", d, 0);

        // R2 R3 byte order, last, filler skip (10 bytes then 4 bytes)
        send_frame(10);
        push_word(32'hF0E0_D0C0);
        send_frame(4);
        compare_stream("R2/R3");
        drain_status("R5");

        // R4 underrun, then clean frame
        push_word(32'h0403_0201);
        send_frame(9);
        compare_stream("R4");
        drain_status("R4");
        push_word(32'h1111_2222);
        push_word(32'h3333_4444);
        send_frame(6);
        compare_stream("R4");
        drain_status("R4");

        // R6 done re-assert, R10 irq
        push_word(32'hA5A5_5A5A);
        push_word(32'h1234_5678);
        send_frame(3);
        send_frame(3);
        compare_stream("R6");
        bus_read(3'd4, d); check(d[0] === 1'b1, "R6", "done set", d, 1);
        bus_write(3'd5, 32'd1);
        @(negedge clk);
        check(irq === 1'b1, "R10", "irq with done enabled", 32'(irq), 1);
        bus_read(3'd6, d); check(d[1] === 1'b1, "R10", "DEV summary", d, 2);
        bus_read(3'd3, d); check(d === stat_q[0], "R5", "status pop", d, stat_q[0]);
        void'(stat_q.pop_front());
        bus_write(3'd4, 32'd1);
        bus_read(3'd4, d); check(d[0] === 1'b1, "R6", "done stays with status queued", d, 1);
        bus_read(3'd3, d); check(d === stat_q[0], "R5", "status pop", d, stat_q[0]);
        void'(stat_q.pop_front());
        bus_write(3'd4, 32'd1);
        bus_read(3'd4, d); check(d[0] === 1'b0, "R6", "done clears when empty", d, 0);
        @(negedge clk);
        check(irq === 1'b0, "R10", "irq after clear", 32'(irq), 0);
        bus_read(3'd6, d); check(d[1] === 1'b0, "R10", "DEV summary clears", d, 0);
        bus_write(3'd5, 32'd0);

        // R5 empty status read
        bus_read(3'd3, d); check(d === 0, "R5", "empty status read", d, 0);
        bus_read(3'd4, d); check(d[4] === 1'b1, "R5", "status underflow bit4", d, 32'h10);
        bus_write(3'd4, 32'h1F);
        bus_read(3'd4, d); check(d[4] === 1'b1, "R9", "bit4 survives W1C", d, 32'h10);
        soft_reset();

        // R7 length queue full
        rdy_mode = 0;
        push_word(32'h0000_0001);
        for (int i = 0; i < 18; i++) bus_write(3'd2, 32'd4);
        bus_read(3'd4, d); check(d[2:1] === 2'b11, "R7", "full and overflow bits", d, 32'h6);
        bus_write(3'd4, 32'h1F);
        bus_read(3'd4, d); check(d[2] === 1'b1, "R9", "bit2 survives W1C", d, 32'h4);
        soft_reset();
        rdy_mode = 2;
        bus_read(3'd4, d); check(d === 0, "R11", "ISR after soft reset", d, 0);
        repeat (10) @(negedge clk);
        check(tx_valid === 1'b0, "R11", "engine idle after soft reset", 32'(tx_valid), 0);

        // R8 packet FIFO overflow
        for (int i = 0; i < 513; i++) bus_write(3'd1, 32'(i));
        bus_read(3'd6, d); check(d[0] === 1'b1, "R8", "packet overflow flag", d, 1);
        bus_write(3'd4, 32'h1F);
        bus_read(3'd6, d); check(d[0] === 1'b1, "R8", "flag sticky", d, 1);
        soft_reset();
        bus_read(3'd6, d); check(d[0] === 1'b0, "R11", "flag cleared by soft reset", d, 0);
        push_word(32'hDEAD_BEEF);
        send_frame(2);
        compare_stream("R11");
        drain_status("R11");

        // R9 status queue overflow
        for (int i = 0; i < 17; i++) push_word(32'h100 + 32'(i));
        for (int i = 0; i < 17; i++) begin
            bus_write(3'd2, 32'd1);
            model_frame(1, i < 16);
        end
        compare_stream("R9");
        bus_read(3'd4, d); check(d[3] === 1'b1, "R9", "status overflow bit3", d, 32'h8);
        drain_status("R9");
        bus_read(3'd3, d); check(d === 0, "R9", "dropped status absent", d, 0);
        soft_reset();

        // random frames with back-pressure
        rdy_mode = 1;
        for (int b = 0; b < 4; b++) begin
            for (int f = 0; f < 8; f++) begin
                int len = $urandom_range(1, 40);
                for (int w = 0; w < (len + 3) / 4; w++) push_word($urandom);
                send_frame(len);
            end
            compare_stream("R2");
            drain_status("R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule